// File: doc/BRIEF.md
# T1/E1 Receive Overhead Data-Link Extractor

This block sits behind a receive framer that has already locked onto the line. On every line-bit strobe, the framer supplies the recovered bit together with its position in the frame and the frame number within the multiframe. The block picks out the overhead bits that the selected framing format reserves for the data link. It presents each of them on a serial data pin. A companion clock pin lets a downstream device shift them in.

The data pin carries every overhead bit of the chosen format, whatever else is configured. The clock pin pulses only for the bits configured to carry the data link. It stays quiet while the internal HDLC receiver owns the link and while the framer reports loss of frame.

In T1 mode, four formats are selectable:
- Extended superframe: the data-link bits in the framing slots, with a full-rate or half-rate clock.
- SLC96 and N: the signalling framing bits.
- Digital-multiplexed format: the R bit of the sync byte.

In E1 mode, the national bits of timeslot 0 are extracted. A five-bit mask chooses which of them are clocked.

Top module: `oh_extract`

## Requirements
- R1: While rst_ni is low, oh_data_o and oh_clk_o are 0, and both stay 0 after reset until overhead stimulus arrives.
- R2: With e1_mode_i=0 and t1_fmt_i=0 (extended superframe), the bit at bit_pos_i=0 of each frame with an even frame_idx_i (0..22) drives oh_data_o.
- R3: In extended superframe, esf_4k_i=1 pulses oh_clk_o for all twelve data-link bits of a 24-frame multiframe. esf_4k_i=0 pulses it only for frame_idx_i values that are multiples of 4, which gives six pulses per multiframe. oh_data_o still follows all twelve bits.
- R4: With t1_fmt_i=1 (SLC96) or t1_fmt_i=2 (N), the bit at bit_pos_i=0 of each frame with an odd frame_idx_i drives oh_data_o and is clocked.
- R5: With t1_fmt_i=3 (digital-multiplexed), the bit at bit_pos_i=191 (the R bit of the channel-24 sync byte) in every frame drives oh_data_o and is clocked.
- R6: With e1_mode_i=1, in frames with an odd frame_idx_i (0..15), the bits at bit_pos_i 3..7 (Sa4..Sa8) drive oh_data_o whatever the value of sa_dl_mask_i.
- R7: In E1 mode, a national bit is clocked only if sa_dl_mask_i[bit_pos_i-3] is 1 (bit 0 selects Sa4, bit 4 selects Sa8).
- R8: oh_data_o changes only on a cycle that carries bit_en_i at an overhead position. Line bits at any other position are ignored, and the last overhead bit is held.
- R9: bit_en_i must never be high on two consecutive cycles. oh_clk_o is 0 on the cycle after any bit_en_i. For a clocked bit, oh_clk_o rises two cycles after the capturing bit_en_i and stays high with oh_data_o stable until the next bit_en_i.
- R10: While hdlc_en_i is 1, oh_clk_o is 0 from the following cycle on, while oh_data_o keeps updating.
- R11: While lof_i is 1, oh_clk_o is 0 from the following cycle on, while oh_data_o keeps updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_bit_i | input | 1 | Recovered line bit |
| bit_en_i | input | 1 | Line-bit valid strobe |
| bit_pos_i | input | POS_W (8) | Bit position within the frame (T1 0..192, E1 0..255) |
| frame_idx_i | input | MF_W (5) | Frame number within the multiframe (T1 0..23, E1 0..15) |
| e1_mode_i | input | 1 | 1 = E1, 0 = T1 |
| t1_fmt_i | input | 2 | T1 format: 0 ESF, 1 SLC96, 2 N, 3 digital-multiplexed |
| sa_dl_mask_i | input | SA_N (5) | Per-national-bit data-link enable, bit 0 = Sa4 |
| esf_4k_i | input | 1 | 1 = full-rate ESF clock, 0 = half rate |
| hdlc_en_i | input | 1 | Internal HDLC receiver owns the data link |
| lof_i | input | 1 | Framer reports loss of frame |
| oh_data_o | output | 1 | Serial overhead data |
| oh_clk_o | output | 1 | Overhead clock, data valid on rising edge |

## Verification
Three kinds of internal fault are distinct at the ports:
- A position decoder that selects the wrong slot latches a payload bit onto oh_data_o. This is visible on the cycle after that bit's strobe, long before the next genuine overhead slot.
- A wrong data-link qualification, such as the rate select or the mask, shows as a missing or extra oh_clk_o pulse two cycles after the capturing strobe. The per-multiframe pulse count exposes it within one multiframe.
- A strobe stage that fails to drop or gate the clock shows as oh_clk_o high on the cycle after a bit strobe, or during HDLC ownership or loss of frame.

// File: rtl/oh_extract_pkg.sv
package oh_extract_pkg;

  typedef enum logic [1:0] {
    FMT_ESF = 2'd0,
    FMT_SLC = 2'd1,
    FMT_NFR = 2'd2,
    FMT_DM  = 2'd3
  } t1_fmt_e;

  typedef struct packed {
    logic hit;  // overhead position, drives data pin
    logic dl;   // position carries data link, drives clock pin
  } oh_slot_t;

  localparam int T1_FRAMES   = 24;
  localparam int E1_FRAMES   = 16;
  localparam int T1_FBIT_POS = 0;

endpackage

// File: rtl/oh_t1_locate.sv
module oh_t1_locate
  import oh_extract_pkg::*;
#(
  parameter int POS_W    = 8,
  parameter int MF_W     = 5,
  parameter int DM_R_POS = 191
) (
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic [MF_W-1:0]  frame_idx_i,
  input  logic [1:0]       fmt_i,
  input  logic             esf_4k_i,
  output oh_slot_t         slot_o
);

  localparam logic [POS_W-1:0] FBIT = POS_W'(T1_FBIT_POS);
  localparam logic [POS_W-1:0] RPOS = POS_W'(DM_R_POS);
  localparam logic [MF_W-1:0]  NFR  = MF_W'(T1_FRAMES);

  logic    f_slot;
  logic    in_mf;
  t1_fmt_e fmt;

  assign fmt    = t1_fmt_e'(fmt_i);
  assign in_mf  = frame_idx_i < NFR;
  assign f_slot = (bit_pos_i == FBIT) && in_mf;

  always_comb begin
    slot_o = '0;
    unique case (fmt)
      FMT_ESF: begin
        // data-link bits sit in frames 1,3,..,23 (even index)
        slot_o.hit = f_slot && !frame_idx_i[0];
        // half rate keeps every second one
        slot_o.dl  = slot_o.hit && (esf_4k_i || !frame_idx_i[1]);
      end
      FMT_SLC, FMT_NFR: begin
        slot_o.hit = f_slot && frame_idx_i[0];
        slot_o.dl  = slot_o.hit;
      end
      FMT_DM: begin
        slot_o.hit = (bit_pos_i == RPOS) && in_mf;
        slot_o.dl  = slot_o.hit;
      end
      default: slot_o = '0;
    endcase
  end

endmodule

// File: rtl/oh_e1_locate.sv
module oh_e1_locate
  import oh_extract_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int MF_W  = 5,
  parameter int SA_LO = 3,
  parameter int SA_N  = 5
) (
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic [MF_W-1:0]  frame_idx_i,
  input  logic [SA_N-1:0]  sa_dl_mask_i,
  output oh_slot_t         slot_o
);

  localparam logic [MF_W-1:0] NFR = MF_W'(E1_FRAMES);

  logic [SA_N-1:0] sa_match;
  logic            nfas;

  // frames without the alignment word have odd index
  assign nfas = frame_idx_i[0] && (frame_idx_i < NFR);

  for (genvar gi = 0; gi < SA_N; gi++) begin : g_sa
    assign sa_match[gi] = (bit_pos_i == POS_W'(SA_LO + gi));
  end

  assign slot_o.hit = nfas && (|sa_match);
  assign slot_o.dl  = nfas && (|(sa_match & sa_dl_mask_i));

endmodule

// File: rtl/oh_strobe_gen.sv
module oh_strobe_gen
  import oh_extract_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  logic     line_bit_i,
  input  oh_slot_t slot_i,
  input  logic     block_i,
  output logic     oh_data_o,
  output logic     oh_clk_o
);

  logic data_q, clk_q, rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      clk_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      if (bit_en_i && slot_i.hit) data_q <= line_bit_i;
      if (bit_en_i) begin
        // falling edge coincides with data change
        clk_q  <= 1'b0;
        rise_q <= slot_i.dl && !block_i;
      end else begin
        rise_q <= 1'b0;
        if (block_i)     clk_q <= 1'b0;
        else if (rise_q) clk_q <= 1'b1;
      end
    end
  end

  assign oh_data_o = data_q;
  assign oh_clk_o  = clk_q;

endmodule

// File: rtl/oh_extract.sv
module oh_extract
  import oh_extract_pkg::*;
#(
  parameter int POS_W    = 8,
  parameter int MF_W     = 5,
  parameter int SA_LO    = 3,
  parameter int SA_N     = 5,
  parameter int DM_R_POS = 191
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_bit_i,
  input  logic             bit_en_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic [MF_W-1:0]  frame_idx_i,
  input  logic             e1_mode_i,
  input  logic [1:0]       t1_fmt_i,
  input  logic [SA_N-1:0]  sa_dl_mask_i,
  input  logic             esf_4k_i,
  input  logic             hdlc_en_i,
  input  logic             lof_i,
  output logic             oh_data_o,
  output logic             oh_clk_o
);

  oh_slot_t t1_slot, e1_slot, slot;
  logic     block;

  oh_t1_locate #(
    .POS_W   (POS_W),
    .MF_W    (MF_W),
    .DM_R_POS(DM_R_POS)
  ) u_t1 (
    .bit_pos_i  (bit_pos_i),
    .frame_idx_i(frame_idx_i),
    .fmt_i      (t1_fmt_i),
    .esf_4k_i   (esf_4k_i),
    .slot_o     (t1_slot)
  );

  oh_e1_locate #(
    .POS_W(POS_W),
    .MF_W (MF_W),
    .SA_LO(SA_LO),
    .SA_N (SA_N)
  ) u_e1 (
    .bit_pos_i   (bit_pos_i),
    .frame_idx_i (frame_idx_i),
    .sa_dl_mask_i(sa_dl_mask_i),
    .slot_o      (e1_slot)
  );

  assign slot  = e1_mode_i ? e1_slot : t1_slot;
  assign block = hdlc_en_i || lof_i;

  oh_strobe_gen u_strb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .line_bit_i(line_bit_i),
    .slot_i    (slot),
    .block_i   (block),
    .oh_data_o (oh_data_o),
    .oh_clk_o  (oh_clk_o)
  );

endmodule

// File: rtl/oh_extract_chk.sv
module oh_extract_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic hdlc_en_i,
  input logic lof_i,
  input logic oh_data_o,
  input logic oh_clk_o
);

  // R9
  en_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> !bit_en_i);

  // R9
  clk_low_after_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> !oh_clk_o);

  // R9
  rise_after_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oh_clk_o) |-> ($past(bit_en_i, 2) && !$past(bit_en_i)));

  // R9
  data_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_clk_o |-> $stable(oh_data_o));

  // R8
  data_only_on_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> $stable(oh_data_o));

  // R10
  hdlc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdlc_en_i |=> !oh_clk_o);

  // R11
  lof_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lof_i |=> !oh_clk_o);

endmodule

bind oh_extract oh_extract_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .hdlc_en_i(hdlc_en_i),
  .lof_i    (lof_i),
  .oh_data_o(oh_data_o),
  .oh_clk_o (oh_clk_o)
);

// File: tb/tb_oh_extract.sv
`timescale 1ns/1ps
module tb_oh_extract;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_bit_i = 1'b0;
  logic       bit_en_i = 1'b0;
  logic [7:0] bit_pos_i = '0;
  logic [4:0] frame_idx_i = '0;
  logic       e1_mode_i = 1'b0;
  logic [1:0] t1_fmt_i = '0;
  logic [4:0] sa_dl_mask_i = '0;
  logic       esf_4k_i = 1'b1;
  logic       hdlc_en_i = 1'b0;
  logic       lof_i = 1'b0;
  logic       oh_data_o, oh_clk_o;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic m_data = 1'b0, m_clk = 1'b0, m_rise = 1'b0;
  logic prev_clk = 1'b0;
  int   mism, nrise, nexp;
  logic [63:0] rec_v, exp_v;

  always #10 clk_i = ~clk_i;

  oh_extract dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_bit_i(line_bit_i), .bit_en_i(bit_en_i),
    .bit_pos_i(bit_pos_i), .frame_idx_i(frame_idx_i), .e1_mode_i(e1_mode_i),
    .t1_fmt_i(t1_fmt_i), .sa_dl_mask_i(sa_dl_mask_i), .esf_4k_i(esf_4k_i),
    .hdlc_en_i(hdlc_en_i), .lof_i(lof_i), .oh_data_o(oh_data_o), .oh_clk_o(oh_clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(int f, int p, int s);
    return ((f * 13 + p * 7 + s) % 5) < 2;
  endfunction

  function automatic bit is_oh(int f, int p);
    if (e1_mode_i) return (f % 2 == 1) && f < 16 && p >= 3 && p <= 7;
    case (t1_fmt_i)
      2'd0:    return p == 0 && f % 2 == 0 && f < 24;
      2'd1,
      2'd2:    return p == 0 && f % 2 == 1 && f < 24;
      default: return p == 191 && f < 24;
    endcase
  endfunction

  function automatic bit is_dl(int f, int p);
    if (!is_oh(f, p)) return 1'b0;
    if (e1_mode_i) return sa_dl_mask_i[p-3];
    if (t1_fmt_i == 2'd0) return esf_4k_i || (f % 4 == 0);
    return 1'b1;
  endfunction

  // one system cycle; model follows R8/R9/R10/R11
  task automatic step(input bit en, input int f, input int p, input bit b);
    bit blk;
    @(negedge clk_i);
    bit_en_i = en; bit_pos_i = 8'(p); frame_idx_i = 5'(f); line_bit_i = b;
    blk = hdlc_en_i || lof_i;
    @(posedge clk_i);
    if (en && is_oh(f, p)) m_data = b;
    if (en) begin
      m_clk = 1'b0;
      m_rise = is_dl(f, p) && !blk;
      if (m_rise) begin exp_v[nexp] = b; nexp++; end
    end else begin
      if (blk) m_clk = 1'b0;
      else if (m_rise) m_clk = 1'b1;
      m_rise = 1'b0;
    end
    #2;
    if (oh_data_o !== m_data || oh_clk_o !== m_clk) mism++;
    if (oh_clk_o && !prev_clk) begin
      if (nrise < 64) rec_v[nrise] = oh_data_o;
      nrise++;
    end
    prev_clk = oh_clk_o;
  endtask

  task automatic run_mf(input string req, input int nfr, input int gap,
                        input int seed, input int exp_pulses);
    int fbits;
    fbits = e1_mode_i ? 256 : 193;
    mism = 0; nrise = 0; nexp = 0; rec_v = '0; exp_v = '0;
    for (int f = 0; f < nfr; f++)
      for (int p = 0; p < fbits; p++) begin
        step(1'b1, f, p, pat(f, p, seed));
        for (int g = 0; g < gap; g++) step(1'b0, f, p, 1'b0);
      end
    chk(mism == 0, {req, " cycle trace"}, mism, 0);
    chk(nrise == exp_pulses, {req, " pulse count"}, nrise, exp_pulses);
    chk(rec_v == exp_v, {req, " clocked data"}, int'(rec_v[31:0]), int'(exp_v[31:0]));
  endtask

  task automatic t_reset;
    #3;
    chk(oh_data_o === 1'b0 && oh_clk_o === 1'b0, "R1 in reset", {oh_data_o, oh_clk_o}, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    chk(oh_data_o === 1'b0 && oh_clk_o === 1'b0, "R1 after reset", {oh_data_o, oh_clk_o}, 0);
  endtask

  task automatic t_esf;
    e1_mode_i = 0; t1_fmt_i = 2'd0; esf_4k_i = 1; hdlc_en_i = 0; lof_i = 0;
    run_mf("R2 R3 esf 4k", 24, 1, 1, 12);
    esf_4k_i = 0;
    run_mf("R3 esf 2k", 24, 1, 2, 6);
  endtask

  task automatic t_hold;
    logic held;
    // R8: payload positions with both values must not disturb the held bit
    held = oh_data_o;
    mism = 0;
    for (int p = 1; p < 9; p++) begin
      step(1'b1, 0, p, ~held);
      step(1'b0, 0, p, ~held);
      if (oh_data_o !== held) mism++;
    end
    chk(mism == 0, "R8 payload ignored", mism, 0);
  endtask

  task automatic t_slc_n;
    esf_4k_i = 1; t1_fmt_i = 2'd1;
    run_mf("R4 slc96", 24, 1, 3, 12);
    t1_fmt_i = 2'd2;
    run_mf("R4 n format", 24, 1, 4, 12);
  endtask

  task automatic t_dm;
    t1_fmt_i = 2'd3;
    run_mf("R5 dm", 4, 1, 5, 4);
    run_mf("R5 R9 dm sparse", 4, 3, 6, 4);
  endtask

  task automatic t_e1;
    e1_mode_i = 1; sa_dl_mask_i = 5'b11111;
    run_mf("R6 R7 e1 all", 16, 1, 7, 40);
    sa_dl_mask_i = 5'b10101;
    run_mf("R7 e1 sa4 sa6 sa8", 16, 1, 8, 24);
    sa_dl_mask_i = 5'b00000;
    run_mf("R6 e1 none clocked", 16, 1, 9, 0);
  endtask

  task automatic t_block;
    e1_mode_i = 0; t1_fmt_i = 2'd0; esf_4k_i = 1; hdlc_en_i = 1;
    run_mf("R10 hdlc owns", 24, 1, 10, 0);
    hdlc_en_i = 0; e1_mode_i = 1; sa_dl_mask_i = 5'b11111; lof_i = 1;
    run_mf("R11 lof", 16, 1, 11, 0);
    lof_i = 0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_esf();
    t_hold();
    t_slc_n();
    t_dm();
    t_e1();
    t_block();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule